// File: doc/BRIEF.md
# Indexed Per-Pin Configuration Bank

This block keeps the configuration of eight general-purpose pins behind a small indexed window on a byte-wide configuration bus. Each pin owns three stored bytes: a first configuration byte, an event-routing byte and a second configuration byte. Software does not address these 24 bytes directly. It first writes a pin number into a select register. Three data addresses then reach the three bytes of that pin only.

All stored bytes drive parallel output buses, one byte lane per pin, so that the event logic can use every pin's settings at the same time. Reads are registered. Read data appears on the cycle after the read strobe and is zero on every other cycle. Every register is cleared by the standby-domain reset only. Loss of main power does not affect them.

Top module: `pin_cfg_bank`

## Requirements
- R1: After the standby reset (synchronous, active low), the select register reads 00h and, for every pin, the first configuration byte is 00h, the routing byte is 01h and the second configuration byte is 00h.
- R2: Address F0h writes and reads the full 8-bit select register. All eight bits read back exactly as written.
- R3: Only select bits [2:0] choose the pin. Bits [7:3] are stored but have no effect on which pin the data addresses reach.
- R4: A write to F1h replaces the first configuration byte of the selected pin. The bytes of the other seven pins do not change. Pin p's byte is output on `cfg1_o[8p+7:8p]`.
- R5: A write to F2h replaces the routing byte of the selected pin only. Pin p's byte is output on `route_o[8p+7:8p]`.
- R6: A write to F3h replaces the second configuration byte of the selected pin only. Pin p's byte is output on `cfg2_o[8p+7:8p]`.
- R7: A read strobe on F1h, F2h or F3h returns the addressed byte of the pin selected at that moment on `rdata` one clock after the strobe.
- R8: A read of any address outside F0h to F3h returns 00h. A write to such an address changes no register.
- R9: `rdata` is 00h on any cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_sb_n | input | 1 | Standby-domain reset, synchronous, active low |
| bus_addr | input | 8 | Configuration register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data, valid the cycle after `bus_rd` |
| cfg1_o | output | 64 | First configuration byte of every pin, pin p in byte lane p |
| route_o | output | 64 | Routing byte of every pin, pin p in byte lane p |
| cfg2_o | output | 64 | Second configuration byte of every pin, pin p in byte lane p |

## Verification
Every stored byte is visible on a parallel output. A write that lands on the wrong pin, a write that spills into a neighbour, or a wrong reset value therefore shows up on the output buses one cycle after the write strobe. A wrong pin index or a decode error in the read path shows up only on `rdata`, one cycle after a read strobe. For that reason the bench reads back every pin through the window, and it uses select values with the upper bits set as well as clear. Writes and reads to unmapped addresses are checked on both the output buses and `rdata`, so that an address alias cannot go unseen.

// File: rtl/pin_cfg_pkg.sv
// Package: shared constants and types for the indexed pin configuration bank.
// Assumes an 8-bit configuration address space and byte-wide registers.
package pin_cfg_pkg;

    localparam int          CFG_DW        = 8;
    localparam logic [7:0]  ADR_SEL       = 8'hF0;
    localparam logic [7:0]  ADR_CFG1      = 8'hF1;
    localparam logic [7:0]  ADR_ROUTE     = 8'hF2;
    localparam logic [7:0]  ADR_CFG2      = 8'hF3;

    localparam logic [7:0]  RST_SEL       = 8'h00;
    localparam logic [7:0]  RST_CFG1      = 8'h00;
    localparam logic [7:0]  RST_ROUTE     = 8'h01;
    localparam logic [7:0]  RST_CFG2      = 8'h00;

    // Which register a bus address reaches.
    typedef enum logic [2:0] {
        KIND_NONE  = 3'd0,
        KIND_SEL   = 3'd1,
        KIND_CFG1  = 3'd2,
        KIND_ROUTE = 3'd3,
        KIND_CFG2  = 3'd4
    } reg_kind_e;

endpackage

// File: rtl/pin_cfg_decode.sv
// Module: address decoder for the indexed window.
// What it does: maps a bus address to the register kind it reaches.
// Assumes: the four window addresses are distinct. Every other address decodes to KIND_NONE.
module pin_cfg_decode
    import pin_cfg_pkg::*;
#(
    parameter int         ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] A_SEL   = ADDR_W'(ADR_SEL),
    parameter logic [ADDR_W-1:0] A_CFG1  = ADDR_W'(ADR_CFG1),
    parameter logic [ADDR_W-1:0] A_ROUTE = ADDR_W'(ADR_ROUTE),
    parameter logic [ADDR_W-1:0] A_CFG2  = ADDR_W'(ADR_CFG2)
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind
);

    // Purpose: compare the address against the four window addresses.
    always_comb begin
        if (addr == A_SEL)        kind = KIND_SEL;
        else if (addr == A_CFG1)  kind = KIND_CFG1;
        else if (addr == A_ROUTE) kind = KIND_ROUTE;
        else if (addr == A_CFG2)  kind = KIND_CFG2;
        else                      kind = KIND_NONE;
    end

endmodule

// File: rtl/pin_cfg_set.sv
// Module: the three stored configuration bytes of one pin.
// What it does: holds the first configuration byte, the routing byte and the second
// configuration byte, each loaded by its own write enable.
// Assumes: the parent qualifies each enable with the pin select, so at most one set
// sees an enable in any cycle.
module pin_cfg_set
    import pin_cfg_pkg::*;
#(
    parameter int            DW        = CFG_DW,
    parameter logic [DW-1:0] CFG1_RST  = DW'(RST_CFG1),
    parameter logic [DW-1:0] ROUTE_RST = DW'(RST_ROUTE),
    parameter logic [DW-1:0] CFG2_RST  = DW'(RST_CFG2)
) (
    input  logic          clk,
    input  logic          rst_sb_n,
    input  logic          we_cfg1,
    input  logic          we_route,
    input  logic          we_cfg2,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cfg1_q,
    output logic [DW-1:0] route_q,
    output logic [DW-1:0] cfg2_q
);

    // Purpose: first configuration byte storage.
    always_ff @(posedge clk) begin
        if (!rst_sb_n)    cfg1_q <= CFG1_RST;
        else if (we_cfg1) cfg1_q <= wdata;
    end

    // Purpose: event-routing byte storage.
    always_ff @(posedge clk) begin
        if (!rst_sb_n)     route_q <= ROUTE_RST;
        else if (we_route) route_q <= wdata;
    end

    // Purpose: second configuration byte storage.
    always_ff @(posedge clk) begin
        if (!rst_sb_n)    cfg2_q <= CFG2_RST;
        else if (we_cfg2) cfg2_q <= wdata;
    end

endmodule

// File: rtl/pin_cfg_rdmux.sv
// Module: read-data selector for the indexed window.
// What it does: picks the select register or one byte lane of the selected pin,
// according to the decoded register kind. Unmapped kinds give zero.
// Assumes: NUM_PINS is a power of two, so every pin index is in range.
module pin_cfg_rdmux
    import pin_cfg_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int DW       = CFG_DW,
    localparam int SEL_W   = $clog2(NUM_PINS),
    localparam int TOT_W   = NUM_PINS * DW
) (
    input  reg_kind_e        kind,
    input  logic [DW-1:0]    sel_reg,
    input  logic [SEL_W-1:0] pin_idx,
    input  logic [TOT_W-1:0] cfg1_all,
    input  logic [TOT_W-1:0] route_all,
    input  logic [TOT_W-1:0] cfg2_all,
    output logic [DW-1:0]    rd_next
);

    // Purpose: choose the byte a read of this address returns.
    always_comb begin
        unique case (kind)
            KIND_SEL:   rd_next = sel_reg;
            KIND_CFG1:  rd_next = cfg1_all[pin_idx*DW +: DW];
            KIND_ROUTE: rd_next = route_all[pin_idx*DW +: DW];
            KIND_CFG2:  rd_next = cfg2_all[pin_idx*DW +: DW];
            default:    rd_next = '0;
        endcase
    end

endmodule

// File: rtl/pin_cfg_bank.sv
// Module: indexed per-pin configuration bank (top).
// What it does: holds a select register and NUM_PINS sets of three configuration
// bytes. The select register's low bits bank three data addresses onto one pin's set.
// It drives every pin's bytes as parallel outputs and returns registered read data.
// Assumes: one-cycle bus strobes, NUM_PINS a power of two, and a synchronous
// active-low standby reset as the only reset of this state.
module pin_cfg_bank
    import pin_cfg_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int DW       = CFG_DW,
    parameter int ADDR_W   = 8,
    localparam int SEL_W   = $clog2(NUM_PINS),
    localparam int TOT_W   = NUM_PINS * DW
) (
    input  logic              clk,
    input  logic              rst_sb_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     rdata,
    output logic [TOT_W-1:0]  cfg1_o,
    output logic [TOT_W-1:0]  route_o,
    output logic [TOT_W-1:0]  cfg2_o
);

    reg_kind_e        kind;
    logic [DW-1:0]    sel_q;
    logic [SEL_W-1:0] pin_idx;
    logic [DW-1:0]    rd_next;

    assign pin_idx = sel_q[SEL_W-1:0];

    pin_cfg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .kind (kind)
    );

    // Purpose: select register, stored in full and read back in full.
    always_ff @(posedge clk) begin
        if (!rst_sb_n)                     sel_q <= DW'(RST_SEL);
        else if (bus_wr && kind == KIND_SEL) sel_q <= bus_wdata;
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic hit;
        assign hit = bus_wr && (pin_idx == SEL_W'(p));

        pin_cfg_set #(.DW(DW)) u_set (
            .clk      (clk),
            .rst_sb_n (rst_sb_n),
            .we_cfg1  (hit && kind == KIND_CFG1),
            .we_route (hit && kind == KIND_ROUTE),
            .we_cfg2  (hit && kind == KIND_CFG2),
            .wdata    (bus_wdata),
            .cfg1_q   (cfg1_o[p*DW +: DW]),
            .route_q  (route_o[p*DW +: DW]),
            .cfg2_q   (cfg2_o[p*DW +: DW])
        );
    end

    pin_cfg_rdmux #(.NUM_PINS(NUM_PINS), .DW(DW)) u_rdmux (
        .kind      (kind),
        .sel_reg   (sel_q),
        .pin_idx   (pin_idx),
        .cfg1_all  (cfg1_o),
        .route_all (route_o),
        .cfg2_all  (cfg2_o),
        .rd_next   (rd_next)
    );

    // Purpose: register read data for one cycle after a strobe, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_sb_n)   rdata <= '0;
        else if (bus_rd) rdata <= rd_next;
        else             rdata <= '0;
    end

endmodule

// File: rtl/pin_cfg_bank_chk.sv
// Module: property checker for pin_cfg_bank, attached with bind.
// What it does: checks how the port-level state changes after writes and reads.
// Assumes: the same parameters as the bound instance.
module pin_cfg_bank_chk
    import pin_cfg_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int DW       = CFG_DW,
    parameter int ADDR_W   = 8,
    localparam int SEL_W   = $clog2(NUM_PINS),
    localparam int TOT_W   = NUM_PINS * DW
) (
    input logic              clk,
    input logic              rst_sb_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DW-1:0]     bus_wdata,
    input logic [DW-1:0]     rdata,
    input logic [TOT_W-1:0]  cfg1_o,
    input logic [TOT_W-1:0]  route_o,
    input logic [TOT_W-1:0]  cfg2_o,
    input logic [DW-1:0]     sel_q
);

    logic in_win;
    logic [TOT_W-1:0] lane_mask;

    assign in_win = (bus_addr >= ADDR_W'(ADR_SEL)) && (bus_addr <= ADDR_W'(ADR_CFG2));
    assign lane_mask = {{(TOT_W-DW){1'b0}}, {DW{1'b1}}} << (DW * int'(sel_q[SEL_W-1:0]));

    AST_OOR_WR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_sb_n)
        (bus_wr && !in_win) |=> ($stable(cfg1_o) && $stable(route_o) && $stable(cfg2_o) && $stable(sel_q))); // R8
    AST_OOR_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_sb_n)
        (bus_rd && !in_win) |=> (rdata == '0)); // R8
    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_sb_n)
        !bus_rd |=> (rdata == '0)); // R9
    AST_SEL_WRITE: assert property (@(posedge clk) disable iff (!rst_sb_n)
        (bus_wr && bus_addr == ADDR_W'(ADR_SEL)) |=> (sel_q == $past(bus_wdata))); // R2
    AST_CFG1_SEL_ONLY: assert property (@(posedge clk) disable iff (!rst_sb_n)
        (bus_wr && bus_addr == ADDR_W'(ADR_CFG1)) |=> (((cfg1_o ^ $past(cfg1_o)) & ~$past(lane_mask)) == '0)); // R4
    AST_ROUTE_SEL_ONLY: assert property (@(posedge clk) disable iff (!rst_sb_n)
        (bus_wr && bus_addr == ADDR_W'(ADR_ROUTE)) |=> (((route_o ^ $past(route_o)) & ~$past(lane_mask)) == '0)); // R5
    AST_CFG2_SEL_ONLY: assert property (@(posedge clk) disable iff (!rst_sb_n)
        (bus_wr && bus_addr == ADDR_W'(ADR_CFG2)) |=> (((cfg2_o ^ $past(cfg2_o)) & ~$past(lane_mask)) == '0)); // R6
    AST_NO_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_sb_n)
        !bus_wr |=> ($stable(cfg1_o) && $stable(route_o) && $stable(cfg2_o) && $stable(sel_q))); // R4

endmodule

bind pin_cfg_bank pin_cfg_bank_chk #(.NUM_PINS(NUM_PINS), .DW(DW), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_sb_n  (rst_sb_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .rdata     (rdata),
    .cfg1_o    (cfg1_o),
    .route_o   (route_o),
    .cfg2_o    (cfg2_o),
    .sel_q     (sel_q)
);

// File: tb/pin_cfg_bank_tb.sv
// Bench: scoreboard for pin_cfg_bank. Read tasks push expected bytes into a queue,
// and a monitor pops and compares them when rdata is due. Output buses are checked
// against a reference model kept in the bench.
module pin_cfg_bank_tb;

    localparam int NP = 8;

    logic        clk = 1'b0;
    logic        rst_sb_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  rdata;
    logic [63:0] cfg1_o, route_o, cfg2_o;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [7:0] m_sel;
    logic [7:0] m_c1 [NP];
    logic [7:0] m_rt [NP];
    logic [7:0] m_c2 [NP];

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       rd_pend = 1'b0;

    always #4 clk = ~clk;

    pin_cfg_bank u_dut (
        .clk (clk), .rst_sb_n (rst_sb_n), .bus_addr (bus_addr), .bus_wr (bus_wr),
        .bus_rd (bus_rd), .bus_wdata (bus_wdata), .rdata (rdata),
        .cfg1_o (cfg1_o), .route_o (route_o), .cfg2_o (cfg2_o)
    );

    task automatic model_reset();
        m_sel = 8'h00;
        for (int p = 0; p < NP; p++) begin
            m_c1[p] = 8'h00; m_rt[p] = 8'h01; m_c2[p] = 8'h00;
        end
    endtask

    function automatic logic [7:0] model_read(input logic [7:0] a);
        case (a)
            8'hF0:   return m_sel;
            8'hF1:   return m_c1[m_sel[2:0]];
            8'hF2:   return m_rt[m_sel[2:0]];
            8'hF3:   return m_c2[m_sel[2:0]];
            default: return 8'h00;
        endcase
    endfunction

    task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        case (a)
            8'hF0: m_sel = d;
            8'hF1: m_c1[m_sel[2:0]] = d;
            8'hF2: m_rt[m_sel[2:0]] = d;
            8'hF3: m_c2[m_sel[2:0]] = d;
            default: ;
        endcase
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [7:0] a, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(model_read(a));
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_outs(input string tag);
        for (int p = 0; p < NP; p++) begin
            n_vec++;
            if (cfg1_o[p*8 +: 8] !== m_c1[p] || route_o[p*8 +: 8] !== m_rt[p] ||
                cfg2_o[p*8 +: 8] !== m_c2[p]) begin
                n_bad++;
                $display("FAIL %s pin %0d: got %h/%h/%h expected %h/%h/%h", tag, p,
                         cfg1_o[p*8 +: 8], route_o[p*8 +: 8], cfg2_o[p*8 +: 8],
                         m_c1[p], m_rt[p], m_c2[p]);
            end
        end
    endtask

    // Monitor: note each read strobe at the edge that captures it.
    always @(posedge clk) begin
        rd_pend <= bus_rd;
        cycles  <= cycles + 1;
    end

    // Monitor: compare rdata half a cycle after the capturing edge.
    always @(negedge clk) begin
        if (rst_sb_n && !done) begin
            n_vec++;
            if (rd_pend) begin
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R7 unexpected read result: got %h expected none", rdata);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (rdata !== e) begin
                        n_bad++;
                        $display("FAIL %s read: got %h expected %h", t, rdata, e);
                    end
                end
            end else if (rdata !== 8'h00) begin
                n_bad++;
                $display("FAIL R9 idle rdata: got %h expected 00", rdata);
            end
        end
    end

    // Watchdog: a hung run is counted as a failure and still ends with the summary.
    always @(posedge clk) begin
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected under 100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        rst_sb_n = 1'b1;
        @(negedge clk);
        chk_outs("R1 reset values");
        do_rd(8'hF0, "R1 select reset");
        do_rd(8'hF2, "R1 routing reset");
        do_rd(8'hF1, "R1 cfg1 reset");

        // R4 R5 R6: fill every pin with a distinct pattern.
        for (int p = 0; p < NP; p++) begin
            do_wr(8'hF0, 8'(p));
            do_wr(8'hF1, 8'(8'h10 + p));
            chk_outs("R4 cfg1 write selected pin");
            do_wr(8'hF2, 8'(8'hA0 ^ (p * 7)));
            chk_outs("R5 routing write selected pin");
            do_wr(8'hF3, 8'(8'h5C + p * 3));
            chk_outs("R6 cfg2 write selected pin");
        end

        // R7: read back every pin, walking the select downward.
        for (int p = NP - 1; p >= 0; p--) begin
            do_wr(8'hF0, 8'(p));
            do_rd(8'hF1, "R7 cfg1 readback");
            do_rd(8'hF2, "R7 routing readback");
            do_rd(8'hF3, "R7 cfg2 readback");
        end

        // R2 R3: upper select bits are stored but do not steer.
        do_wr(8'hF0, 8'hAD);
        do_rd(8'hF0, "R2 full select readback");
        do_rd(8'hF1, "R3 upper bits ignored cfg1");
        do_wr(8'hF2, 8'h3E);
        chk_outs("R3 upper bits ignored write");
        do_wr(8'hF0, 8'hF8);
        do_rd(8'hF0, "R2 select F8 readback");
        do_rd(8'hF3, "R3 select F8 reaches pin0");

        // R8: unmapped writes and reads.
        do_wr(8'hF4, 8'hFF);
        do_wr(8'h00, 8'hFF);
        do_wr(8'hEF, 8'hFF);
        do_wr(8'h70, 8'hFF);
        chk_outs("R8 unmapped write no effect");
        do_rd(8'hF0, "R8 select unchanged");
        do_rd(8'hF4, "R8 unmapped read zero");
        do_rd(8'hEF, "R8 unmapped read zero");
        do_rd(8'h71, "R8 unmapped read zero");

        // Back-to-back reads: no idle cycle between strobes.
        @(negedge clk);
        bus_addr = 8'hF2; bus_rd = 1'b1;
        exp_q.push_back(model_read(8'hF2)); tag_q.push_back("R7 back-to-back 1");
        @(negedge clk);
        bus_addr = 8'hF0;
        exp_q.push_back(model_read(8'hF0)); tag_q.push_back("R7 back-to-back 2");
        @(negedge clk);
        bus_rd = 1'b0;
        @(negedge clk);

        // R1: reset again in mid-run.
        rst_sb_n = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_sb_n = 1'b1;
        @(negedge clk);
        chk_outs("R1 reset after use");
        do_rd(8'hF0, "R1 select after reset");
        do_rd(8'hF2, "R1 routing after reset");
        repeat (3) @(negedge clk);

        n_vec++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R7 reads left unanswered: got %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule